// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block executes one data-processing instruction per clock. Each issued operation carries a 4-bit condition code. The block tests that code against its own N/Z/C/V flag register. If the test fails, the operation changes nothing. If it passes, the block applies one of sixteen operations to a first operand and a second operand that an external shifter has already prepared. The shifter's carry-out comes in as a separate input.

A passing operation can do three things. It can write a result to a destination index. It can update the flags, either when its set-flags bit is present or, for the four compare-type operations, always. When the set-flags bit is present and the destination is index 15, it raises a one-cycle request to restore status from the saved copy.

All outputs are registered and appear one cycle after issue. The flag register is updated on the same edge, so back-to-back operations see the flags left by their predecessor.

Top module: `dp_alu`

## Requirements
- R1: The condition code selects the test on the flags: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, 10 N equal to V, 11 N differs from V, 12 Z clear and N equal to V, 13 Z set or N differs from V, 14 always. `flags_o` is {N,Z,C,V} on bits 3..0.
- R2: Condition code 15 never executes. When the condition fails, there is no write and no restore request, and the flags and the held result are unchanged.
- R3: Opcodes 0 AND, 1 EOR, 12 ORR, 13 MOV (result is operand B), 14 BIC (A and not B) and 15 MVN (not B) produce the corresponding logical result.
- R4: Opcodes 2 SUB (A−B), 3 RSB (B−A), 4 ADD, 5 ADC (A+B+C), 6 SBC (A−B−not C) and 7 RSC (B−A−not C) produce the corresponding 32-bit arithmetic result.
- R5: A logical operation that updates flags sets N from result bit 31, Z when the result is zero and C from `shift_c_i`, and leaves V unchanged.
- R6: An arithmetic operation that updates flags sets N and Z from the result. C is the carry-out for addition and not-borrow for subtraction. V is signed overflow.
- R7: Opcodes 8 TST (AND), 9 TEQ (EOR), 10 CMP (A−B) and 11 CMN (A+B) always update the flags, whatever the set-flags bit and destination. They never write and never request a restore.
- R8: A passing non-compare operation with the set-flags bit clear leaves the flags unchanged.
- R9: A passing non-compare operation with the set-flags bit set and destination 15 writes its result to index 15, raises `restore_o` for one cycle and leaves the flags unchanged.
- R10: Results are registered. `wr_en_o` and `restore_o` pulse in the cycle after issue. With `issue_i` low, nothing is written or requested. `result_o` and `wr_idx_o` hold the last written values.
- R11: After reset the flags, `result_o`, `wr_idx_o`, `wr_en_o` and `restore_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | An operation is presented this cycle |
| cond_i | input | 4 | Condition code |
| opcode_i | input | 4 | Operation select |
| set_flags_i | input | 1 | Set-flags bit |
| rd_i | input | 4 | Destination index |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifted second operand |
| shift_c_i | input | 1 | Shifter carry-out |
| result_o | output | 32 | Last written result |
| wr_en_o | output | 1 | Destination write pulse |
| wr_idx_o | output | 4 | Destination index of last write |
| restore_o | output | 1 | Restore-status request pulse |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
The assertions check several rules on every cycle:
- a failed or never-execute condition leaves the flags still and produces no write or restore;
- compare-type operations never write;
- a clear set-flags bit on an ordinary operation holds the flags;
- a restore request always comes with a write to index 15 and unchanged flags;
- a logical flag update keeps V.

Only the bench's reference model can show the values themselves: the results of every opcode, carry and overflow at the arithmetic boundaries, and each condition code chosen against flags produced by earlier operations.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dpa_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } dpa_flags_t;

  // R1 / R2: condition code test against the current flags
  function automatic logic cond_holds(input logic [3:0] code, input dpa_flags_t f);
    logic ok;
    unique case (code)
      4'd0:  ok = f.z;
      4'd1:  ok = !f.z;
      4'd2:  ok = f.c;
      4'd3:  ok = !f.c;
      4'd4:  ok = f.n;
      4'd5:  ok = !f.n;
      4'd6:  ok = f.v;
      4'd7:  ok = !f.v;
      4'd8:  ok = f.c && !f.z;
      4'd9:  ok = !f.c || f.z;
      4'd10: ok = (f.n == f.v);
      4'd11: ok = (f.n != f.v);
      4'd12: ok = !f.z && (f.n == f.v);
      4'd13: ok = f.z || (f.n != f.v);
      4'd14: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic op_is_compare(input dpa_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_is_logical(input dpa_op_e op);
    return op inside {OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN};
  endfunction

endpackage

// File: rtl/dpa_cond_gate.sv
module dpa_cond_gate
  import dpa_pkg::*;
(
  input  logic       issue_i,
  input  logic [3:0] cond_i,
  input  dpa_flags_t flags_i,
  output logic       pass_o,
  output logic       fire_o
);

  assign pass_o = cond_holds(cond_i, flags_i);
  assign fire_o = issue_i && pass_o;

endmodule

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dpa_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              shift_c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] add_x, add_y, logic_r;
  logic              add_ci;
  logic [DATA_W:0]   sum;

  // One adder serves every arithmetic opcode; subtraction is x + ~y + ci.
  always_comb begin
    add_x  = a_i;
    add_y  = b_i;
    add_ci = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin add_y = ~b_i; add_ci = 1'b1;    end
      OP_RSB:         begin add_x = b_i; add_y = ~a_i; add_ci = 1'b1; end
      OP_ADC:         begin add_ci = carry_i; end
      OP_SBC:         begin add_y = ~b_i; add_ci = carry_i; end
      OP_RSC:         begin add_x = b_i; add_y = ~a_i; add_ci = carry_i; end
      default:        ;
    endcase
  end

  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: logic_r = a_i & b_i;
      OP_EOR, OP_TEQ: logic_r = a_i ^ b_i;
      OP_ORR:         logic_r = a_i | b_i;
      OP_BIC:         logic_r = a_i & ~b_i;
      OP_MVN:         logic_r = ~b_i;
      default:        logic_r = b_i;
    endcase
  end

  always_comb begin
    if (op_is_logical(op_i)) begin
      res_o = logic_r;
      c_o   = shift_c_i;
      v_o   = 1'b0;
    end else begin
      res_o = sum[MSB:0];
      c_o   = sum[DATA_W];
      v_o   = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        opcode_i,
  input  logic              set_flags_i,
  input  logic [IDX_W-1:0]  rd_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              shift_c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              restore_o,
  output logic [3:0]        flags_o
);

  localparam logic [IDX_W-1:0] RESTORE_IDX = '1;
  localparam int               MSB         = DATA_W - 1;

  dpa_flags_t        flags_q, flags_nx;
  dpa_op_e           op;
  logic              cond_pass, fire;
  logic [DATA_W-1:0] dp_res;
  logic              dp_c, dp_v;
  logic              is_cmp, is_log, to_restore_idx;
  logic              do_write, do_restore, do_flags;
  logic [DATA_W-1:0] result_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wr_q, restore_q;

  assign op = dpa_op_e'(opcode_i);

  dpa_cond_gate u_gate (
    .issue_i (issue_i),
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (cond_pass),
    .fire_o  (fire)
  );

  dpa_datapath #(.DATA_W(DATA_W)) u_dp (
    .op_i      (op),
    .a_i       (op_a_i),
    .b_i       (op_b_i),
    .carry_i   (flags_q.c),
    .shift_c_i (shift_c_i),
    .res_o     (dp_res),
    .c_o       (dp_c),
    .v_o       (dp_v)
  );

  assign is_cmp         = op_is_compare(op);
  assign is_log         = op_is_logical(op);
  assign to_restore_idx = (rd_i == RESTORE_IDX);

  // Named events used by the checker
  assign do_write   = fire && !is_cmp;
  assign do_restore = do_write && set_flags_i && to_restore_idx;
  assign do_flags   = fire && (is_cmp || (set_flags_i && !to_restore_idx));

  always_comb begin
    flags_nx.n = dp_res[MSB];
    flags_nx.z = (dp_res == '0);
    flags_nx.c = dp_c;
    flags_nx.v = is_log ? flags_q.v : dp_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      result_q  <= '0;
      idx_q     <= '0;
      wr_q      <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      wr_q      <= do_write;
      restore_q <= do_restore;
      if (do_write) begin
        result_q <= dp_res;
        idx_q    <= rd_i;
      end
      if (do_flags) flags_q <= flags_nx;
    end
  end

  assign result_o  = result_q;
  assign wr_en_o   = wr_q;
  assign wr_idx_o  = idx_q;
  assign restore_o = restore_q;
  assign flags_o   = flags_q;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [3:0]       cond_i,
  input logic [3:0]       opcode_i,
  input logic             set_flags_i,
  input logic [IDX_W-1:0] rd_i,
  input logic             cond_pass,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             restore_o,
  input logic [3:0]       flags_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = '1;

  logic cmp_op, log_op;
  assign cmp_op = (opcode_i[3:2] == 2'b10);
  assign log_op = opcode_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15};

  assert_cond_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !cond_pass |=> !wr_en_o && !restore_o && $stable(flags_o));

  assert_never_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && cond_i == 4'hF |=> !wr_en_o && !restore_o);

  assert_compare_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && cmp_op |=> !wr_en_o && !restore_o);

  assert_no_s_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !set_flags_i && !cmp_op |=> $stable(flags_o));

  assert_restore_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> wr_en_o && wr_idx_o == TOP_IDX && flags_o == $past(flags_o));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !wr_en_o && !restore_o);

  assert_logic_keeps_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && cond_pass && log_op && (set_flags_i || cmp_op) && rd_i != TOP_IDX
    |=> flags_o[0] == $past(flags_o[0]));

endmodule

bind dp_alu dp_alu_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_i     (issue_i),
  .cond_i      (cond_i),
  .opcode_i    (opcode_i),
  .set_flags_i (set_flags_i),
  .rd_i        (rd_i),
  .cond_pass   (cond_pass),
  .wr_en_o     (wr_en_o),
  .wr_idx_o    (wr_idx_o),
  .restore_o   (restore_o),
  .flags_o     (flags_o)
);

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  cond_i = 4'd14;
  logic [3:0]  opcode_i = 4'd0;
  logic        set_flags_i = 1'b0;
  logic [3:0]  rd_i = 4'd0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        shift_c_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  wr_idx_o;
  logic        restore_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;

  // model state: {N,Z,C,V}
  logic [3:0]  m_flags = 4'd0;
  logic [31:0] m_result = '0;
  logic [3:0]  m_idx = '0;
  logic        m_wr = 1'b0;
  logic        m_rst = 1'b0;

  always #2.5 clk = ~clk;

  dp_alu i_dp_alu (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .cond_i(cond_i),
    .opcode_i(opcode_i), .set_flags_i(set_flags_i), .rd_i(rd_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .shift_c_i(shift_c_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .restore_o(restore_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_cond(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;          1: return !z;
      2: return cy;         3: return !cy;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return cy && !z;   9: return !cy || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      14: return 1;
      default: return 0;
    endcase
  endfunction

  // issue one operation (or idle), advance the model, compare after the edge
  task automatic step(input bit iss, input logic [3:0] cnd, input logic [3:0] op,
                      input bit s, input logic [3:0] rd, input logic [31:0] a,
                      input logic [31:0] b, input bit sc, input string tag);
    longint unsigned ua, ub, cin, nc;
    longint sa, sb, sres;
    logic [31:0] r;
    bit cy, v, logical, cmp, pass, wr, rest, upd;
    @(negedge clk);
    issue_i = iss; cond_i = cnd; opcode_i = op; set_flags_i = s;
    rd_i = rd; op_a_i = a; op_b_i = b; shift_c_i = sc;
    ua = a; ub = b; sa = longint'($signed(a)); sb = longint'($signed(b));
    cin = m_flags[1]; nc = 1 - cin;
    logical = op inside {0, 1, 8, 9, 12, 13, 14, 15};
    cmp = op inside {8, 9, 10, 11};
    cy = sc; v = m_flags[0]; sres = 0;
    case (op)
      0, 8:  r = a & b;
      1, 9:  r = a ^ b;
      12:    r = a | b;
      13:    r = b;
      14:    r = a & ~b;
      15:    r = ~b;
      2, 10: begin r = 32'(ua - ub); cy = ua >= ub; sres = sa - sb; end
      3:     begin r = 32'(ub - ua); cy = ub >= ua; sres = sb - sa; end
      4, 11: begin r = 32'(ua + ub); cy = (ua + ub) > 64'hFFFF_FFFF; sres = sa + sb; end
      5:     begin r = 32'(ua + ub + cin); cy = (ua + ub + cin) > 64'hFFFF_FFFF; sres = sa + sb + longint'(cin); end
      6:     begin r = 32'(ua - ub - nc); cy = ua >= ub + nc; sres = sa - sb - longint'(nc); end
      default: begin r = 32'(ub - ua - nc); cy = ub >= ua + nc; sres = sb - sa - longint'(nc); end
    endcase
    if (!logical) v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    pass = iss && m_cond(cnd, m_flags);
    wr   = pass && !cmp;
    rest = wr && s && rd == 4'd15;
    upd  = pass && (cmp || (s && rd != 4'd15));
    if (wr) begin m_result = r; m_idx = rd; end
    if (upd) m_flags = {r[31], r == 32'd0, cy, v};
    @(posedge clk);
    #1;
    check(tag, "wr_en", wr_en_o, wr);
    check(tag, "restore", restore_o, rest);
    check(tag, "result", result_o, m_result);
    check(tag, "wr_idx", wr_idx_o, m_idx);
    check(tag, "flags", flags_o, m_flags);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check("R11", "flags", flags_o, 0);
    check("R11", "result", result_o, 0);
    check("R11", "wr_en", wr_en_o, 0);
    check("R11", "restore", restore_o, 0);
    check("R11", "wr_idx", wr_idx_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R5: logical flag update, C from shifter, V kept
    step(1, 14, 13, 1, 1, 0, 0, 1, "R5");
    // R7: CMP equal -> Z C set, no write
    step(1, 14, 10, 0, 2, 5, 5, 0, "R7");
    // R1: EQ passes, NE fails (R2)
    step(1, 0, 4, 0, 3, 10, 20, 0, "R1");
    step(1, 1, 4, 0, 4, 11, 22, 0, "R2");
    // borrow: CMP 3,5 -> N set, C clear
    step(1, 14, 10, 1, 0, 3, 5, 0, "R6");
    step(1, 11, 13, 0, 5, 0, 32'h55, 0, "R1");
    step(1, 10, 13, 0, 6, 0, 32'h66, 0, "R1");
    step(1, 9, 13, 0, 7, 0, 32'h77, 0, "R1");
    step(1, 8, 13, 0, 8, 0, 32'h88, 0, "R1");
    // signed overflow on ADD
    step(1, 14, 4, 1, 1, 32'h7FFF_FFFF, 1, 0, "R6");
    step(1, 6, 13, 0, 2, 0, 32'h1234, 0, "R1");
    step(1, 12, 13, 0, 3, 0, 32'h4321, 0, "R1");
    // R5: logical keeps V=1
    step(1, 14, 1, 1, 4, 32'hF0F0, 32'h0F0F, 0, "R5");
    // carry and zero from ADD
    step(1, 14, 4, 1, 5, 32'hFFFF_FFFF, 1, 0, "R6");
    // R4: ADC with C set, SBC/RSC with C clear
    step(1, 14, 5, 0, 6, 1, 1, 0, "R4");
    step(1, 14, 10, 1, 0, 3, 5, 0, "R4");
    step(1, 14, 6, 0, 7, 10, 3, 0, "R4");
    step(1, 14, 7, 1, 8, 3, 10, 0, "R4");
    step(1, 14, 3, 1, 9, 3, 10, 0, "R4");
    step(1, 14, 2, 1, 9, 32'h8000_0000, 1, 0, "R6");
    // R3: logical results
    step(1, 14, 14, 0, 10, 32'hFF, 32'h0F, 0, "R3");
    step(1, 14, 15, 0, 11, 0, 0, 0, "R3");
    step(1, 14, 0, 0, 12, 32'hF00F, 32'hFF00, 0, "R3");
    step(1, 14, 12, 0, 13, 32'hF000, 32'h000F, 0, "R3");
    // R7: TST with S clear still updates flags
    step(1, 14, 8, 0, 0, 32'h8000_0000, 32'h8000_0001, 1, "R7");
    // R8: ADD without S leaves flags
    step(1, 14, 4, 0, 1, 32'hFFFF_FFFF, 1, 0, "R8");
    // R9: MOVS to 15 requests restore
    step(1, 14, 13, 1, 15, 0, 0, 0, "R9");
    step(1, 14, 10, 1, 15, 1, 1, 0, "R7");
    // R2: never code
    step(1, 15, 13, 1, 4, 0, 32'hDEAD, 1, "R2");
    // R10: idle holds
    step(0, 14, 13, 1, 6, 0, 32'hBEEF, 1, "R10");
    step(0, 14, 4, 0, 7, 1, 1, 0, "R10");
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = (i % 4 == 0) ? a : $urandom;
      step((i % 7) != 0, 4'($urandom), 4'($urandom), 1'($urandom),
           4'($urandom), a, b, 1'($urandom), "R1/R4 mix");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule